// File: doc/BRIEF.md
# SDRAM Power-Down and Reset Sequencer

This block is the control sequencer of an SDRAM controller. It decides when the memory clock-enable pin is driven and when the command scheduler may issue commands. It reacts to two active-low resets with different reach, and it moves the memory into and out of power-down on request. The memory clock keeps running throughout. Power-down is the low-latency saving mode, and waking from it costs only a short, programmable hold-off.

The device reset clears everything, the exit-delay register included. The module soft reset restarts only the sequencing logic, so software does not have to program the timing again. When the last active reset is released, the sequencer starts initialization without waiting for software. Initialization is modelled as a fixed countdown. While either reset is held, the internal command and data FIFOs are flushed. Register accesses made during that time get an error response, so a bus master does not stall.

The exit-delay register holds the value T. After a wake request, clock enable rises first, and commands stay blocked for T+1 controller clock cycles.

Top module: `sdram_pd_seq`

## Requirements
- R1: While `chip_rst_n` is low, `cke`, `cmd_ok`, `init_start` and `init_done` are 0, and the exit-delay register returns to `TXP_RST`.
- R2: While `soft_rst_n` is low (with `chip_rst_n` high), `cke`, `cmd_ok` and `init_done` are 0, and the exit-delay register keeps its programmed value.
- R3: On the first rising clock edge with both resets high, `init_start` goes to 1 for exactly one cycle, and `cke` goes to 1 on that same edge.
- R4: `cmd_ok` and `init_done` rise together `INIT_CYC` cycles after `init_start` rose. A `pd_req` that arrives before then is ignored.
- R5: `fifo_flush` is 1 exactly while at least one reset input is low.
- R6: A read or write (`reg_rd`/`reg_wr`) made while either reset is low sets `reg_err` to 1 and returns `reg_rdata` of 0, and a write made then does not change the register. Outside reset, `reg_err` is 0 and a read returns the exit-delay value T held in bits [TXP_W-1:0].
- R7: In idle, `pd_req` with `cmd_pending` low is accepted, and `cke` and `cmd_ok` are 0 from the next cycle. While `cmd_pending` is high the request is refused and `cke` stays 1.
- R8: In power-down, `wake_req` drives `cke` to 1 on the next edge. `cmd_ok` then stays 0 for exactly T+1 cycles counted from that edge, including when T is 0.
- R9: A `wake_req` that arrives during the exit wait is ignored, and the exit countdown is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| chip_rst_n | input | 1 | Device reset, active low, clears sequencer and register |
| soft_rst_n | input | 1 | Module soft reset, active low, clears sequencer only |
| pd_req | input | 1 | Request to enter power-down |
| wake_req | input | 1 | Request to leave power-down |
| cmd_pending | input | 1 | Scheduler still holds commands |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | TXP_W | Exit-delay value to write |
| reg_rdata | output | TXP_W | Read data |
| reg_err | output | 1 | Error response for an access made during reset |
| cke | output | 1 | SDRAM clock enable |
| cmd_ok | output | 1 | Scheduler may issue commands |
| init_start | output | 1 | One-cycle initialization start strobe |
| init_done | output | 1 | Initialization complete flag |
| fifo_flush | output | 1 | Discard queued commands and data |

## Verification
The bench loads random exit delays, including 0 and the largest value, and counts the cycles in which `cmd_ok` stays low after each wake. A design off by one would open one cycle early or late, and a design that reloads its counter on a second wake would hold commands off too long. Power-down requests are tried while commands are still pending and during initialization. A design that failed to refuse them would drop `cke` there. A soft reset is applied between power-down rounds and the register is read back afterwards, so a design that wiped the configuration on a soft reset shows the default value. Register accesses made during both kinds of reset must return an error and leave the value unchanged.

// File: rtl/sdram_pd_seq.sv
module sdram_pd_seq #(
  parameter int TXP_W    = 4,
  parameter int TXP_RST  = 3,
  parameter int INIT_CYC = 20
) (
  input  logic             clk,
  input  logic             chip_rst_n,
  input  logic             soft_rst_n,
  input  logic             pd_req,
  input  logic             wake_req,
  input  logic             cmd_pending,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [TXP_W-1:0] reg_wdata,
  output logic [TXP_W-1:0] reg_rdata,
  output logic             reg_err,
  output logic             cke,
  output logic             cmd_ok,
  output logic             init_start,
  output logic             init_done,
  output logic             fifo_flush
);

  localparam int INIT_W = $clog2(INIT_CYC + 1);
  localparam int CNT_W  = (TXP_W > INIT_W) ? TXP_W : INIT_W;

  typedef enum logic [2:0] {S_RST, S_INIT, S_IDLE, S_PD, S_XW} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [TXP_W-1:0] t_xp;
  logic             seq_rst_n;

  assign seq_rst_n  = chip_rst_n & soft_rst_n;
  assign fifo_flush = ~seq_rst_n;
  assign reg_err    = (reg_wr | reg_rd) & ~seq_rst_n;
  assign reg_rdata  = (reg_rd && seq_rst_n) ? t_xp : '0;
  assign cmd_ok     = (st == S_IDLE);

  always_ff @(posedge clk or negedge chip_rst_n)
    if (!chip_rst_n)                t_xp <= TXP_W'(TXP_RST);
    else if (reg_wr && soft_rst_n)  t_xp <= reg_wdata;

  always_ff @(posedge clk or negedge seq_rst_n)
    if (!seq_rst_n) begin
      st         <= S_RST;
      cnt        <= '0;
      cke        <= 1'b0;
      init_start <= 1'b0;
      init_done  <= 1'b0;
    end else begin
      case (st)
        S_RST: begin
          st         <= S_INIT;
          cnt        <= CNT_W'(INIT_CYC - 1);
          cke        <= 1'b1;
          init_start <= 1'b1;
        end
        S_INIT: begin
          init_start <= 1'b0;
          if (cnt == '0) begin
            st        <= S_IDLE;
            init_done <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        S_IDLE:
          if (pd_req && !cmd_pending) begin
            st  <= S_PD;
            cke <= 1'b0;
          end
        S_PD:
          if (wake_req) begin
            st  <= S_XW;
            cke <= 1'b1;
            cnt <= CNT_W'(t_xp);
          end
        S_XW:
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        default: st <= S_RST;
      endcase
    end

  assert_start_cke_R3: assert property (@(posedge clk) disable iff (!seq_rst_n)
    init_start |-> cke);
  assert_cmd_after_init_R4: assert property (@(posedge clk) disable iff (!seq_rst_n)
    cmd_ok |-> init_done);
  assert_accept_pd_R7: assert property (@(posedge clk) disable iff (!seq_rst_n)
    (cmd_ok && pd_req && !cmd_pending) |=> (!cke && !cmd_ok));
  assert_refuse_pd_R7: assert property (@(posedge clk) disable iff (!seq_rst_n)
    (cmd_ok && cmd_pending) |=> cke);
  assert_no_cmd_in_pd_R8: assert property (@(posedge clk) disable iff (!seq_rst_n)
    !cke |-> !cmd_ok);
  assert_exit_hold_R8: assert property (@(posedge clk) disable iff (!seq_rst_n)
    (st == S_XW) |-> (cke && !cmd_ok));
  assert_soft_keeps_cfg_R2: assert property (@(posedge clk) disable iff (!chip_rst_n)
    !soft_rst_n |=> $stable(t_xp));
  always_comb
    if (reg_err) assert_err_no_data_R6: assert (reg_rdata == '0);

endmodule

// File: tb/tb_sdram_pd_seq.sv
module tb_sdram_pd_seq;
  localparam int TXP_W = 4, TXP_RST = 3, INIT_CYC = 20;

  logic clk = 0, chip_rst_n = 0, soft_rst_n = 1;
  logic pd_req = 0, wake_req = 0, cmd_pending = 0, reg_wr = 0, reg_rd = 0;
  logic [TXP_W-1:0] reg_wdata = '0, reg_rdata;
  logic reg_err, cke, cmd_ok, init_start, init_done, fifo_flush;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  sdram_pd_seq #(.TXP_W(TXP_W), .TXP_RST(TXP_RST), .INIT_CYC(INIT_CYC)) dut (.*);

  always #2.5 clk = ~clk;

  function automatic int exit_hold(int t);
    return t + 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(output int v, output int e);
    reg_rd = 1; #1; v = reg_rdata; e = reg_err; reg_rd = 0; #0.5;
  endtask

  task automatic wr(int v);
    reg_wdata = TXP_W'(v); reg_wr = 1; tick(); reg_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic run_init(bool_pd_early);
    tick();
    chk("R3 init_start", init_start, 1);
    chk("R3 cke", cke, 1);
    chk("R5 flush off", fifo_flush, 0);
    if (bool_pd_early) pd_req = 1;
    for (int i = 1; i <= INIT_CYC; i++) begin
      if (i == INIT_CYC - 2) pd_req = 0;
      tick();
      if (i == 1) chk("R3 pulse one cycle", init_start, 0);
      chk("R4 cmd_ok timing", cmd_ok, i == INIT_CYC);
      chk("R4 init_done timing", init_done, i == INIT_CYC);
      chk("R4 pd_req ignored in init", cke, 1);
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog R4 actual=%0d expected=%0d", cyc, 0);
        finish_run();
      end
    end
  end

  initial begin
    int v, e, t;
    void'($urandom(32'd1234));
    repeat (3) tick();
    chk("R1 cke", cke, 0); chk("R1 cmd_ok", cmd_ok, 0);
    chk("R1 init_start", init_start, 0); chk("R1 init_done", init_done, 0);
    chk("R5 flush in chip reset", fifo_flush, 1);
    reg_wdata = 4'd9; reg_wr = 1; #1;
    chk("R6 err on write in reset", reg_err, 1);
    tick(); reg_wr = 0;
    rd(v, e);
    chk("R6 err on read in reset", e, 1); chk("R6 rdata zero in reset", v, 0);
    chip_rst_n = 1;
    run_init(1);
    rd(v, e);
    chk("R1 default exit delay", v, TXP_RST); chk("R6 no err", e, 0);

    for (int it = 0; it < 40; it++) begin
      t = (it == 0) ? 0 : (it == 1) ? 15 : int'($urandom_range(0, 15));
      wr(t);
      rd(v, e);
      chk("R6 readback", v, t);
      if ($urandom_range(0, 1) == 1) begin
        cmd_pending = 1; pd_req = 1; tick();
        chk("R7 refused while pending", cke, 1);
        chk("R7 cmd_ok kept", cmd_ok, 1);
        cmd_pending = 0;
      end
      pd_req = 1; tick(); pd_req = 0;
      chk("R7 cke low after accept", cke, 0);
      chk("R7 cmd_ok low after accept", cmd_ok, 0);
      repeat ($urandom_range(0, 3)) begin
        tick(); chk("R7 stays in power-down", cke, 0);
      end
      wake_req = 1; tick(); wake_req = 0;
      chk("R8 cke high on wake", cke, 1);
      chk("R8 hold starts", cmd_ok, 0);
      begin
        int rew = int'($urandom_range(1, 16));
        for (int k = 1; k <= exit_hold(t); k++) begin
          if (k == rew) wake_req = 1;
          tick();
          wake_req = 0;
          chk(k == rew ? "R9 rewake ignored" : "R8 exit hold", cmd_ok, k == exit_hold(t));
          chk("R8 cke stays high", cke, 1);
        end
      end
      if (it % 13 == 5) begin
        soft_rst_n = 0; #1;
        chk("R2 cke", cke, 0); chk("R2 cmd_ok", cmd_ok, 0);
        chk("R2 init_done", init_done, 0); chk("R5 flush in soft reset", fifo_flush, 1);
        reg_wdata = TXP_W'(t + 1); reg_wr = 1; #1;
        chk("R6 err in soft reset", reg_err, 1);
        tick(); reg_wr = 0;
        soft_rst_n = 1;
        run_init(0);
        rd(v, e);
        chk("R2 config kept", v, t);
      end
    end

    wr(7);
    chip_rst_n = 0; #1;
    chk("R1 cke", cke, 0);
    tick(); chip_rst_n = 1;
    rd(v, e);
    chk("R1 config cleared", v, TXP_RST);
    run_init(0);
    finish_run();
  end
endmodule